// File: doc/BRIEF.md
# Predicated Vector Issue Splitter

This block turns one vectorised operation into a short run of dense scalar issue groups. An operation arrives with three fields: a base element index, a count of elements still to run, and a predicate mask with one bit per element. The block keeps the operation in a single recirculating slot. On each issue cycle it takes up to `LANES` of the lowest-numbered active elements and sends them to an `LANES`-wide ALU port. It then clears those elements from the slot's mask. Elements whose predicate bit is clear are skipped without costing a cycle, so a sparse vector finishes in as many cycles as its active elements need, divided by the lane count.

Both sides use a valid/ready handshake. Each lane carries a valid bit and the index of the element it holds, which is the base plus the element's position. While an operation is in flight, new operations are held off at the input. This keeps every element of one operation ahead of the next operation.

Top module: `pred_issue_splitter`

## Requirements
- R1: When no operation is held, `in_ready` is 1, and an operation is taken in on a clock edge where `in_valid` and `in_ready` are both 1.
- R2: Only element positions p with `in_mask[p]`=1 and p < `in_count` are ever issued, and a lane holding position p carries index `in_base + p`, taken modulo 2^`IDX_W`.
- R3: Within one issue group, lane 0 holds the lowest remaining active position and the positions rise strictly with lane number. Across groups, every position issued is above all positions issued before it for the same operation.
- R4: An issue group holds min(`LANES`, remaining active elements) elements in lanes 0 upward. Lanes above that have `iss_lane_vld` = 0.
- R5: Elements issued on a cycle where `iss_valid` and `iss_ready` are both 1 are removed from the operation. The operation retires on the edge that issues its last element, and `in_ready` is 1 on the following cycle.
- R6: An operation with no active element (zero mask, or `in_count` = 0) holds the block for exactly one cycle, during which `iss_valid` stays 0.
- R7: `in_ready` is 0 from the edge after an acceptance until the operation retires.
- R8: While `iss_valid` is 1 and `iss_ready` is 0, the issue group (lane valids and indices) stays unchanged on the next cycle.
- R9: During and right after reset, `in_ready` is 1, `iss_valid` is 0 and all lane valids are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Vector operation offered |
| in_ready | output | 1 | Slot free, operation can be taken |
| in_base | input | IDX_W | Index of element position 0 |
| in_count | input | CNT_W | Number of elements in the operation (0..XLEN) |
| in_mask | input | XLEN | Predicate, one bit per element position |
| iss_valid | output | 1 | An issue group is presented |
| iss_ready | input | 1 | ALU port accepts the group |
| iss_lane_vld | output | LANES | Per-lane element valid |
| iss_idx | output | LANES*IDX_W | Per-lane element index, lane 0 in the low bits |

## Verification
The per-cycle reference model is driven with several kinds of mask. A six-of-eight sparse mask whose upper bits lie beyond the count shows whether elements are compacted and whether the count bounds them. A full sixteen-bit mask shows whether groups come out in order and full. Zero masks and a zero count expose the single idle retire cycle. Random masks, bases and counts, issued against a toggling `iss_ready`, separate a correct hold under back-pressure from a design that drops or re-issues elements. A wrapping base checks the modulo index arithmetic.

// File: rtl/pis_pkg.sv
package pis_pkg;

   localparam int PIS_MAX_XLEN = 64;

   typedef logic [PIS_MAX_XLEN-1:0] pis_wide_t;

   // Ones in the low `count` bit positions, saturating at the full width.
   function automatic pis_wide_t pis_span(input int count);
      pis_wide_t m;
      m = '0;
      for (int i = 0; i < PIS_MAX_XLEN; i++) begin
         if (i < count) m[i] = 1'b1;
      end
      return m;
   endfunction

   // Position of the single set bit of a one-hot vector (0 if none).
   function automatic int pis_onehot_pos(input pis_wide_t oh);
      int p;
      p = 0;
      for (int i = 0; i < PIS_MAX_XLEN; i++) begin
         if (oh[i]) p = i;
      end
      return p;
   endfunction

endpackage

// File: rtl/pis_lane_picker.sv
module pis_lane_picker
   import pis_pkg::*;
#(
   parameter int XLEN  = 16,
   parameter int LANES = 4,
   parameter int POS_W = 4
) (
   input  logic [XLEN-1:0]        mask,
   output logic [LANES-1:0]       lane_vld,
   output logic [LANES*POS_W-1:0] lane_pos,
   output logic [XLEN-1:0]        taken
);

   logic [LANES:0][XLEN-1:0] rem;

   assign rem[0] = mask;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [XLEN-1:0] oh;
      pis_wide_t       oh_w;
      assign oh       = rem[l] & (~rem[l] + XLEN'(1));
      assign oh_w     = pis_wide_t'(oh);
      assign lane_vld[l] = |rem[l];
      assign lane_pos[l*POS_W +: POS_W] = POS_W'(pis_onehot_pos(oh_w));
      assign rem[l+1] = rem[l] & ~oh;
   end

   assign taken = mask & ~rem[LANES];

endmodule

// File: rtl/pis_op_slot.sv
module pis_op_slot #(
   parameter int XLEN  = 16,
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] load_base,
   input  logic [XLEN-1:0]  load_mask,
   input  logic             fire,
   input  logic [XLEN-1:0]  taken,
   output logic             busy,
   output logic [IDX_W-1:0] base,
   output logic [XLEN-1:0]  mask
);

   logic [XLEN-1:0] left;
   assign left = mask & ~taken;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         base <= '0;
         mask <= '0;
      end else if (load) begin
         busy <= 1'b1;
         base <= load_base;
         mask <= load_mask;
      end else if (busy) begin
         if (mask == '0) begin
            busy <= 1'b0;
         end else if (fire) begin
            mask <= left;
            if (left == '0) busy <= 1'b0;
         end
      end
   end

   // R5: a retiring slot holds no leftover element
   p_empty_on_retire_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (mask == '0));

endmodule

// File: rtl/pred_issue_splitter.sv
module pred_issue_splitter
   import pis_pkg::*;
#(
   parameter int XLEN  = 16,
   parameter int LANES = 4,
   parameter int IDX_W = 8,
   localparam int POS_W = (XLEN > 1) ? $clog2(XLEN) : 1,
   localparam int CNT_W = $clog2(XLEN + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [IDX_W-1:0]       in_base,
   input  logic [CNT_W-1:0]       in_count,
   input  logic [XLEN-1:0]        in_mask,
   output logic                   iss_valid,
   input  logic                   iss_ready,
   output logic [LANES-1:0]       iss_lane_vld,
   output logic [LANES*IDX_W-1:0] iss_idx
);

   if (XLEN < 2 || XLEN > PIS_MAX_XLEN) begin : g_bad_xlen
      $error("pred_issue_splitter: XLEN out of range");
   end
   if (LANES < 1 || LANES > XLEN) begin : g_bad_lanes
      $error("pred_issue_splitter: LANES must be 1..XLEN");
   end
   if (IDX_W < POS_W) begin : g_bad_idx
      $error("pred_issue_splitter: IDX_W narrower than element position");
   end

   logic                   busy;
   logic [IDX_W-1:0]       base;
   logic [XLEN-1:0]        mask;
   logic [XLEN-1:0]        taken;
   logic [XLEN-1:0]        span;
   logic [LANES-1:0]       pick_vld;
   logic [LANES*POS_W-1:0] pick_pos;
   logic                   load;
   logic                   fire;

   assign span      = XLEN'(pis_span(int'(in_count)));
   assign in_ready  = !busy;
   assign load      = in_valid && in_ready;
   assign iss_valid = busy && (mask != '0);
   assign fire      = iss_valid && iss_ready;

   pis_op_slot #(.XLEN(XLEN), .IDX_W(IDX_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_base (in_base),
      .load_mask (in_mask & span),
      .fire      (fire),
      .taken     (taken),
      .busy      (busy),
      .base      (base),
      .mask      (mask)
   );

   pis_lane_picker #(.XLEN(XLEN), .LANES(LANES), .POS_W(POS_W)) u_pick (
      .mask     (mask),
      .lane_vld (pick_vld),
      .lane_pos (pick_pos),
      .taken    (taken)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_out
      logic [POS_W-1:0] pos;
      assign pos = pick_pos[l*POS_W +: POS_W];
      assign iss_lane_vld[l] = busy && pick_vld[l];
      assign iss_idx[l*IDX_W +: IDX_W] = base + IDX_W'(pos);

      if (l > 0) begin : g_chk
         logic [POS_W-1:0] pos_lo;
         assign pos_lo = pick_pos[(l-1)*POS_W +: POS_W];
         // R4: lanes fill from lane 0 with no gap
         p_dense_r4: assert property (@(posedge clk) disable iff (!rst_n)
            iss_lane_vld[l] |-> iss_lane_vld[l-1]);
         // R3: positions rise with lane number
         p_ascend_r3: assert property (@(posedge clk) disable iff (!rst_n)
            iss_lane_vld[l] |-> (pos > pos_lo));
      end
   end

   // R4: a presented group always uses lane 0
   p_first_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> iss_lane_vld[0]);

   // R7: input closes after an acceptance
   p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   // R8: back-pressure holds the group
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !iss_ready) |=>
         (iss_valid && $stable(iss_lane_vld) && $stable(iss_idx)));

   // R5: an accepted group removes exactly its elements
   p_shrink_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> ($countones(mask) ==
                $past($countones(mask)) - $past($countones(iss_lane_vld))));

   // R6: an empty held operation frees the slot on the next cycle
   p_empty_retire_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_ready && !iss_valid) |=> in_ready);

endmodule

// File: tb/pred_issue_splitter_test.sv
module pred_issue_splitter_test;

   localparam int CLK_PERIOD = 10;
   localparam int XLEN  = 16;
   localparam int LANES = 4;
   localparam int IDX_W = 8;
   localparam int CNT_W = $clog2(XLEN + 1);
   localparam int WATCHDOG = 100000;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   in_valid = 1'b0;
   logic                   in_ready;
   logic [IDX_W-1:0]       in_base = '0;
   logic [CNT_W-1:0]       in_count = '0;
   logic [XLEN-1:0]        in_mask = '0;
   logic                   iss_valid;
   logic                   iss_ready = 1'b1;
   logic [LANES-1:0]       iss_lane_vld;
   logic [LANES*IDX_W-1:0] iss_idx;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   // reference model state
   bit              ref_busy = 1'b0;
   int              ref_base = 0;
   bit [XLEN-1:0]   ref_mask = '0;
   int              last_pos = -1;

   always #(CLK_PERIOD/2) clk = ~clk;

   pred_issue_splitter #(.XLEN(XLEN), .LANES(LANES), .IDX_W(IDX_W)) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_ready     (in_ready),
      .in_base      (in_base),
      .in_count     (in_count),
      .in_mask      (in_mask),
      .iss_valid    (iss_valid),
      .iss_ready    (iss_ready),
      .iss_lane_vld (iss_lane_vld),
      .iss_idx      (iss_idx)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cycles);
      end
   endtask

   // model update on every edge, using inputs that were set at the falling edge
   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         ref_busy = 1'b0;
         ref_mask = '0;
         last_pos = -1;
      end else if (ref_busy) begin
         if (ref_mask == '0) begin
            ref_busy = 1'b0;
         end else if (iss_ready) begin
            int n;
            n = 0;
            for (int i = 0; i < XLEN; i++) begin
               if (ref_mask[i] && n < LANES) begin
                  ref_mask[i] = 1'b0;
                  last_pos = i;
                  n++;
               end
            end
            if (ref_mask == '0) ref_busy = 1'b0;
         end
      end else if (in_valid) begin
         ref_busy = 1'b1;
         ref_base = int'(in_base);
         last_pos = -1;
         for (int i = 0; i < XLEN; i++) ref_mask[i] = in_mask[i] && (i < int'(in_count));
      end
   end

   // compare on every falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int n;
         check(in_ready == !ref_busy, "R1 R7 in_ready", int'(in_ready), int'(!ref_busy));
         check(iss_valid == (ref_busy && ref_mask != '0), "R5 R6 iss_valid",
               int'(iss_valid), int'(ref_busy && ref_mask != '0));
         n = 0;
         for (int i = 0; i < XLEN; i++) begin
            if (ref_busy && ref_mask[i] && n < LANES) begin
               check(iss_lane_vld[n] == 1'b1, "R4 lane valid", int'(iss_lane_vld[n]), 1);
               check(int'(iss_idx[n*IDX_W +: IDX_W]) == ((ref_base + i) % (1 << IDX_W)),
                     "R2 R3 lane index", int'(iss_idx[n*IDX_W +: IDX_W]),
                     (ref_base + i) % (1 << IDX_W));
               check(i > last_pos, "R3 order across groups", i, last_pos + 1);
               n++;
            end
         end
         for (int l = n; l < LANES; l++) begin
            check(iss_lane_vld[l] == 1'b0, "R4 unused lane", int'(iss_lane_vld[l]), 0);
         end
      end
   end

   task automatic send_op(input int base, input int count, input bit [XLEN-1:0] mask);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_base  = IDX_W'(base);
      in_count = CNT_W'(count);
      in_mask  = mask;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic held_cycles(output int n);
      n = 0;
      while (!in_ready) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R9: reset state
      check(in_ready == 1'b1, "R9 in_ready in reset", int'(in_ready), 1);
      check(iss_valid == 1'b0, "R9 iss_valid in reset", int'(iss_valid), 0);
      check(iss_lane_vld == '0, "R9 lanes in reset", int'(iss_lane_vld), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b1, "R9 R1 idle after reset", int'(in_ready), 1);

      // six of eight set, bits beyond count ignored: two groups (R2, R4)
      send_op(10, 8, 16'hFFB7);
      held_cycles(n);
      check(n == 2, "R4 R5 six-active op takes two groups", n, 2);

      // zero mask and zero count: one idle cycle (R6)
      send_op(3, 16, 16'h0000);
      held_cycles(n);
      check(n == 1, "R6 zero mask one cycle", n, 1);
      send_op(3, 0, 16'hFFFF);
      held_cycles(n);
      check(n == 1, "R6 zero count one cycle", n, 1);

      // full mask, wrapping base (R2, R3)
      send_op(250, 16, 16'hFFFF);
      held_cycles(n);
      check(n == 4, "R4 full mask four groups", n, 4);

      // single top element
      send_op(0, 16, 16'h8000);
      held_cycles(n);
      check(n == 1, "R3 single top element", n, 1);

      // back-pressure with a fixed pattern (R8)
      fork
         begin
            for (int k = 0; k < 20; k++) begin
               iss_ready = (k % 3) == 2;
               @(negedge clk);
            end
            iss_ready = 1'b1;
         end
         send_op(7, 13, 16'h1A5F);
      join
      held_cycles(n);

      // random ops under random back-pressure
      fork
         begin
            for (int k = 0; k < 3000; k++) begin
               iss_ready = ($urandom % 4) != 0;
               @(negedge clk);
            end
            iss_ready = 1'b1;
         end
         begin
            for (int k = 0; k < 150; k++) begin
               send_op(int'($urandom % 256), int'($urandom % (XLEN + 1)),
                       XLEN'($urandom));
            end
         end
      join
      held_cycles(n);
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      wait (cycles >= WATCHDOG);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule